// File: doc/BRIEF.md
# Victim Line Buffer With Swap

This block is a small, fully associative store that sits between a direct-mapped first-level cache and the next memory level. It keeps lines that the first level has evicted. Any incoming line may occupy any entry. The first level consults the buffer only after it misses, and always before it sends a request downward.

The first level probes with the full line address of the access that missed. It also presents the line that currently occupies the conflicting set. If the buffer holds the requested line, that line is handed back to the first level. The displaced first-level line takes its place in the same entry, so no next-level access happens. If the buffer does not hold the line, the block raises a request to the next level. After that fill, the first level pushes its evicted line into the buffer through the insert port.

Entries are filled in rotation by a fill pointer. Once every entry is valid, each new insertion overwrites the entry that was inserted longest ago. Both kinds of response appear one clock after the probe, as single-cycle pulses.

Top module: `victim_swap_buffer`

## Requirements
- R1: After reset every entry is invalid, both response outputs are low, and the first probe misses.
- R2: A probe hits only when all AW bits of the probe address equal the address of a valid entry. An address that differs in any bit, including the most significant one, misses.
- R3: On a hit, swap_valid_o is 1 in the cycle after the probe. It carries the stored address and data on swap_addr_o and swap_data_o, and miss_valid_o stays 0.
- R4: On a hit, the matching entry takes the first-level line given with the probe (address and data). A later probe of that address hits and returns that data.
- R5: On a miss, miss_valid_o is 1 in the cycle after the probe, with miss_addr_o equal to the probe address. swap_valid_o stays 0 and the stored contents are unchanged.
- R6: An insertion writes the entry at the fill pointer and advances the pointer by one, modulo N. With all entries valid, the entry inserted longest ago is the one replaced.
- R7: A swap does not move the fill pointer. A line swapped into an entry is replaced at that entry's next turn in the insertion order.
- R8: If a probe hits while the supplied first-level line is marked invalid (l1_valid_i = 0), the entry becomes invalid and that address then misses.
- R9: In a cycle with no probe, neither response output is raised in the next cycle.
- R10: If an insertion and a swap write the same entry in the same cycle, the inserted line is kept. The probe response still reports the entry's old contents.
- R11: A line evicted by a conflicting access and soon re-referenced is recovered by a hit, with no next-level request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| probe_valid_i | input | 1 | First-level miss probe |
| probe_addr_i | input | AW | Line address that missed |
| l1_valid_i | input | 1 | Conflicting first-level line is valid |
| l1_addr_i | input | AW | Line address of the conflicting first-level line |
| l1_data_i | input | DW | Data of the conflicting first-level line |
| ins_valid_i | input | 1 | Insert an evicted line |
| ins_addr_i | input | AW | Line address of the evicted line |
| ins_data_i | input | DW | Data of the evicted line |
| swap_valid_o | output | 1 | Probe hit; returned line valid |
| swap_addr_o | output | AW | Address of the returned line |
| swap_data_o | output | DW | Data of the returned line |
| miss_valid_o | output | 1 | Request to the next level |
| miss_addr_o | output | AW | Line address requested from the next level |

## Verification
Probes are applied to an empty buffer, to a single resident line, and to addresses that differ from a resident line only in the top bit. Together these separate a true full-address match from a partial compare or from leftover reset state. A back-to-back pair of probes, where each passes in the other's line, shows that the exchange really moves the first-level line into the entry, rather than only returning data. Filling past capacity, with swaps mixed in and with an insertion that collides with a swap, tells oldest-inserted replacement apart from replacement by most recent use, and fixes which writer wins the entry. A swap with an invalid first-level line and a conflict-then-re-reference sequence cover entry freeing and recovery without a downstream request.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_MISS = 2'd2
  } rsp_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N  = 8,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]        key_i,
  output logic [N-1:0]         hit_vec_o,
  output logic                 hit_o,
  output logic [IW-1:0]        hit_idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vc_fifo_ptr.sv
module vc_fifo_ptr #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= '0;
    else if (adv_i) begin
      if (ptr_q == IW'(N - 1))  ptr_q <= '0;
      else                      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ptr_q == (($past(ptr_q) == IW'(N - 1)) ? '0 : $past(ptr_q) + 1'b1)));

  p_ptr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ins_we_i,
  input  logic [IW-1:0]        ins_idx_i,
  input  logic [AW-1:0]        ins_addr_i,
  input  logic [DW-1:0]        ins_data_i,
  input  logic                 swp_we_i,
  input  logic [IW-1:0]        swp_idx_i,
  input  logic                 swp_keep_i,
  input  logic [AW-1:0]        swp_addr_i,
  input  logic [DW-1:0]        swp_data_i,
  output logic [N-1:0]         valid_o,
  output logic [N-1:0][AW-1:0] tag_o,
  output logic [N-1:0][DW-1:0] data_o
);
  logic [N-1:0]         valid_q;
  logic [N-1:0][AW-1:0] tag_q;
  logic [N-1:0][DW-1:0] data_q;

  // insertion has priority over a swap on the same entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ins_we_i && ins_idx_i == IW'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= ins_addr_i;
          data_q[i]  <= ins_data_i;
        end else if (swp_we_i && swp_idx_i == IW'(i)) begin
          valid_q[i] <= swp_keep_i;
          tag_q[i]   <= swp_addr_i;
          data_q[i]  <= swp_data_i;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;

  p_ins_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_we_i |=> (valid_q[$past(ins_idx_i)] && tag_q[$past(ins_idx_i)] == $past(ins_addr_i)));

  p_swap_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swp_we_i && swp_keep_i && !(ins_we_i && ins_idx_i == swp_idx_i))
      |=> (valid_q[$past(swp_idx_i)] && tag_q[$past(swp_idx_i)] == $past(swp_addr_i)));

  p_swap_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swp_we_i && !swp_keep_i && !(ins_we_i && ins_idx_i == swp_idx_i))
      |=> !valid_q[$past(swp_idx_i)]);
endmodule

// File: rtl/victim_swap_buffer.sv
module victim_swap_buffer
  import vc_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          probe_valid_i,
  input  logic [AW-1:0] probe_addr_i,
  input  logic          l1_valid_i,
  input  logic [AW-1:0] l1_addr_i,
  input  logic [DW-1:0] l1_data_i,
  input  logic          ins_valid_i,
  input  logic [AW-1:0] ins_addr_i,
  input  logic [DW-1:0] ins_data_i,
  output logic          swap_valid_o,
  output logic [AW-1:0] swap_addr_o,
  output logic [DW-1:0] swap_data_o,
  output logic          miss_valid_o,
  output logic [AW-1:0] miss_addr_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]         ent_valid;
  logic [N-1:0][AW-1:0] ent_tag;
  logic [N-1:0][DW-1:0] ent_data;
  logic [N-1:0]         hit_vec;
  logic                 hit_any;
  logic [IW-1:0]        hit_idx;
  logic [IW-1:0]        fill_ptr;
  logic                 swp_we;

  rsp_e          rsp_q;
  logic [AW-1:0] rsp_addr_q;
  logic [DW-1:0] rsp_data_q;

  vc_match #(.N(N), .AW(AW)) u_match (
    .valid_i   (ent_valid),
    .tag_i     (ent_tag),
    .key_i     (probe_addr_i),
    .hit_vec_o (hit_vec),
    .hit_o     (hit_any),
    .hit_idx_o (hit_idx)
  );

  vc_fifo_ptr #(.N(N)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (ins_valid_i),
    .ptr_o  (fill_ptr)
  );

  assign swp_we = probe_valid_i && hit_any;

  vc_store #(.N(N), .AW(AW), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_we_i   (ins_valid_i),
    .ins_idx_i  (fill_ptr),
    .ins_addr_i (ins_addr_i),
    .ins_data_i (ins_data_i),
    .swp_we_i   (swp_we),
    .swp_idx_i  (hit_idx),
    .swp_keep_i (l1_valid_i),
    .swp_addr_i (l1_addr_i),
    .swp_data_i (l1_data_i),
    .valid_o    (ent_valid),
    .tag_o      (ent_tag),
    .data_o     (ent_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q      <= RSP_NONE;
      rsp_addr_q <= '0;
      rsp_data_q <= '0;
    end else if (!probe_valid_i) begin
      rsp_q <= RSP_NONE;
    end else if (hit_any) begin
      rsp_q      <= RSP_HIT;
      rsp_addr_q <= ent_tag[hit_idx];
      rsp_data_q <= ent_data[hit_idx];
    end else begin
      rsp_q      <= RSP_MISS;
      rsp_addr_q <= probe_addr_i;
    end
  end

  assign swap_valid_o = (rsp_q == RSP_HIT);
  assign swap_addr_o  = rsp_addr_q;
  assign swap_data_o  = rsp_data_q;
  assign miss_valid_o = (rsp_q == RSP_MISS);
  assign miss_addr_o  = rsp_addr_q;

  p_hit_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_resp_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swap_valid_o && miss_valid_o));

  p_probe_answered_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_i |=> (swap_valid_o || miss_valid_o));

  p_miss_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_i |=> (!miss_valid_o || miss_addr_o == $past(probe_addr_i)));

  p_hit_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_i |=> (!swap_valid_o || swap_addr_o == $past(probe_addr_i)));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !probe_valid_i |=> (!swap_valid_o && !miss_valid_o));
endmodule

// File: tb/victim_swap_buffer_bench.sv
module victim_swap_buffer_bench;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          probe_valid_i = 1'b0;
  logic [AW-1:0] probe_addr_i = '0;
  logic          l1_valid_i = 1'b0;
  logic [AW-1:0] l1_addr_i = '0;
  logic [DW-1:0] l1_data_i = '0;
  logic          ins_valid_i = 1'b0;
  logic [AW-1:0] ins_addr_i = '0;
  logic [DW-1:0] ins_data_i = '0;
  logic          swap_valid_o;
  logic [AW-1:0] swap_addr_o;
  logic [DW-1:0] swap_data_o;
  logic          miss_valid_o;
  logic [AW-1:0] miss_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  victim_swap_buffer #(.N(N), .AW(AW), .DW(DW)) u_victim_swap_buffer (
    .clk_i(clk), .rst_ni(rst_ni),
    .probe_valid_i(probe_valid_i), .probe_addr_i(probe_addr_i),
    .l1_valid_i(l1_valid_i), .l1_addr_i(l1_addr_i), .l1_data_i(l1_data_i),
    .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i), .ins_data_i(ins_data_i),
    .swap_valid_o(swap_valid_o), .swap_addr_o(swap_addr_o), .swap_data_o(swap_data_o),
    .miss_valid_o(miss_valid_o), .miss_addr_o(miss_addr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_insert(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ins_valid_i = 1'b1; ins_addr_i = a; ins_data_i = d;
    @(posedge clk); #1;
    ins_valid_i = 1'b0;
  endtask

  // probe; outputs sampled 1 ns after the capturing edge
  task automatic do_probe(input logic [AW-1:0] a, input logic lv,
                          input logic [AW-1:0] la, input logic [DW-1:0] ld);
    @(negedge clk);
    probe_valid_i = 1'b1; probe_addr_i = a;
    l1_valid_i = lv; l1_addr_i = la; l1_data_i = ld;
    @(posedge clk); #1;
    probe_valid_i = 1'b0; l1_valid_i = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
    chk(swap_valid_o && !miss_valid_o, req, {swap_valid_o, miss_valid_o}, 2'b10);
    chk(swap_addr_o == a, req, swap_addr_o, a);
    chk(swap_data_o == d, req, swap_data_o, d);
  endtask

  task automatic expect_miss(input string req, input logic [AW-1:0] a);
    chk(miss_valid_o && !swap_valid_o, req, {swap_valid_o, miss_valid_o}, 2'b01);
    chk(miss_addr_o == a, req, miss_addr_o, a);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(!swap_valid_o && !miss_valid_o, "R1 outputs after reset", {swap_valid_o, miss_valid_o}, 0);
    do_probe(16'h0010, 1'b1, 16'h0999, 32'h0);
    expect_miss("R1 first probe", 16'h0010);
    expect_miss("R5 miss address", 16'h0010);
  endtask

  task automatic t_swap();
    do_reset();
    do_insert(16'h0123, 32'hAAAA0001);
    do_probe(16'h0123, 1'b1, 16'h0456, 32'hBBBB0002);
    expect_hit("R3 hit returns line", 16'h0123, 32'hAAAA0001);
    do_probe(16'h0456, 1'b1, 16'h0123, 32'hAAAA0001);
    expect_hit("R4 swapped-in line", 16'h0456, 32'hBBBB0002);
    @(posedge clk); #1;
    chk(!swap_valid_o && !miss_valid_o, "R9 idle", {swap_valid_o, miss_valid_o}, 0);
    do_probe(16'h8123, 1'b1, 16'h0777, 32'h0);
    expect_miss("R2 top bit differs", 16'h8123);
    do_probe(16'h0123, 1'b1, 16'h0456, 32'hBBBB0002);
    expect_hit("R2 exact match", 16'h0123, 32'hAAAA0001);
  endtask

  task automatic t_fifo();
    do_reset();
    for (int i = 0; i < 5; i++) do_insert(AW'(16'h0100 + i), DW'(32'hD0 + i));
    do_probe(16'h0100, 1'b1, 16'h0200, 32'h0);
    expect_miss("R6 oldest replaced", 16'h0100);
    do_probe(16'h0101, 1'b1, 16'h0200, 32'h0);
    expect_hit("R6 second kept", 16'h0101, 32'hD1);
    do_probe(16'h0104, 1'b1, 16'h0201, 32'h0);
    expect_hit("R6 newest present", 16'h0104, 32'hD4);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 4; i++) do_insert(AW'(16'h0100 + i), DW'(32'hD0 + i));
    do_probe(16'h0100, 1'b1, 16'h0300, 32'hC300);
    expect_hit("R7 swap E0", 16'h0100, 32'hD0);
    do_insert(16'h0104, 32'hD4);
    do_probe(16'h0300, 1'b1, 16'h0400, 32'h0);
    expect_miss("R7 swapped line replaced in turn", 16'h0300);
    do_probe(16'h0101, 1'b1, 16'h0401, 32'h0);
    expect_hit("R7 next entry kept", 16'h0101, 32'hD1);
  endtask

  task automatic t_free();
    do_reset();
    do_insert(16'h0123, 32'hAAAA0001);
    do_probe(16'h0123, 1'b0, 16'h0456, 32'hBBBB0002);
    expect_hit("R8 hit with invalid l1", 16'h0123, 32'hAAAA0001);
    do_probe(16'h0456, 1'b1, 16'h0777, 32'h0);
    expect_miss("R8 entry freed", 16'h0456);
  endtask

  task automatic t_collide();
    do_reset();
    for (int i = 0; i < 4; i++) do_insert(AW'(16'h0100 + i), DW'(32'hD0 + i));
    @(negedge clk);
    probe_valid_i = 1'b1; probe_addr_i = 16'h0100;
    l1_valid_i = 1'b1; l1_addr_i = 16'h0300; l1_data_i = 32'hC300;
    ins_valid_i = 1'b1; ins_addr_i = 16'h0500; ins_data_i = 32'hF5;
    @(posedge clk); #1;
    probe_valid_i = 1'b0; l1_valid_i = 1'b0; ins_valid_i = 1'b0;
    expect_hit("R10 old contents reported", 16'h0100, 32'hD0);
    do_probe(16'h0300, 1'b1, 16'h0600, 32'h0);
    expect_miss("R10 swap write dropped", 16'h0300);
    do_probe(16'h0500, 1'b1, 16'h0601, 32'h0);
    expect_hit("R10 insert kept", 16'h0500, 32'hF5);
  endtask

  task automatic t_recover();
    do_reset();
    // L1 holds A; access to B conflicts
    do_probe(16'h0B00, 1'b1, 16'h0A00, 32'hA0A0);
    expect_miss("R11 B to next level", 16'h0B00);
    do_insert(16'h0A00, 32'hA0A0);
    do_probe(16'h0A00, 1'b1, 16'h0B00, 32'hB0B0);
    expect_hit("R11 A recovered", 16'h0A00, 32'hA0A0);
    chk(!miss_valid_o, "R11 no next-level request", miss_valid_o, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_swap();
        t_fifo();
        t_order();
        t_free();
        t_collide();
        t_recover();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule